// File: doc/BRIEF.md
# Background ECC Scrub Engine

This engine walks the DRAM one burst address at a time. At each address it runs a read-modify-write, so that single-event upsets are repaired before a second upset in the same word makes them uncorrectable. It asks the memory controller for command slots through a request/grant pair. When the controller reports idle, it starts a scrub at once. When the controller stays busy, a pacing counter forces a scrub once its interval runs out, so the walk always moves forward.

During the read phase the controller returns one ECC status pair per beat: correctable and uncorrectable. The write phase then carries two things to the controller:

- A fix flag, which asks for the corrected data to be written back.
- A per-beat poison mask. Each uncorrectable beat marks its whole aligned group of 2 or 4 beats.

The engine raises no notification of any kind. It keeps walking after a burst with uncorrectable beats. The burst length, poison group size, pacing mode and end of the address space come from static configuration inputs.

Top module: `scrub_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `scrub_req`, `wb_fix` and `wb_poison` are 0 and `scrub_addr` is 0.
- R2: When the engine is waiting and `ctl_idle` is high at a clock edge, `scrub_req` is high from that edge on, with `scrub_wr`=0 and `scrub_force`=0.
- R3: With `ctl_idle` held low and `cfg_fixed`=0, the next read request rises exactly `cfg_interval`+1 cycles after the edge that granted the previous read, with `scrub_force`=1.
- R4: With `cfg_fixed`=1 at a read grant, the next forced read request rises `FIXED_TICKS`+1 cycles after that grant.
- R5: An ungranted request stays high, and `scrub_addr` and `scrub_wr` keep their values until `scrub_gnt` is seen high.
- R6: After a read is granted, the engine takes one beat per cycle in which `rd_valid` is high. Bit i of the status belongs to beat i, counted from 0. The burst is 16 beats when `cfg_bl16`=1 and 8 beats otherwise. The cycle after the last beat, a write request (`scrub_wr`=1) appears at the same address.
- R7: `wb_fix` is 1 on the write request if and only if some beat of the read had `rd_ce` high. A burst with no uncorrectable beat gives a `wb_poison` of 0.
- R8: With `cfg_grp4`=0, an uncorrectable beat b sets `wb_poison` bits 2*floor(b/2) and 2*floor(b/2)+1. For example, beat 1 gives 0x0003.
- R9: With `cfg_grp4`=1, an uncorrectable beat b sets the four bits from 4*floor(b/4) upward. For example, beat 6 gives 0x00F0 and beats 6 and 13 give 0xF0F0.
- R10: A burst with both correctable and uncorrectable beats gives `wb_fix`=1 together with the OR of the poison groups of every uncorrectable beat.
- R11: After each write grant, the address steps by one. After `cfg_last_addr` it wraps to 0.
- R12: A burst with uncorrectable beats does not halt the walk: the next scrub is issued at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bl16 | input | 1 | 1: 16-beat bursts, 0: 8-beat bursts |
| cfg_grp4 | input | 1 | 1: poison groups of 4 beats, 0: groups of 2 |
| cfg_fixed | input | 1 | 1: fixed pacing interval FIXED_TICKS, 0: cfg_interval |
| cfg_interval | input | IW | Programmable pacing interval in cycles (at least 1) |
| cfg_last_addr | input | AW | Last burst address of the scrubbed space |
| ctl_idle | input | 1 | Controller has an idle slot |
| scrub_gnt | input | 1 | Controller accepts the present scrub command |
| rd_valid | input | 1 | Read-phase status beat valid |
| rd_ce | input | 1 | Beat had a correctable error |
| rd_ue | input | 1 | Beat had an uncorrectable error |
| scrub_req | output | 1 | Scrub command request |
| scrub_wr | output | 1 | 0: read phase, 1: write-back phase |
| scrub_force | output | 1 | Request was forced by the pacing deadline |
| scrub_addr | output | AW | Burst address of the scrub |
| wb_fix | output | 1 | Write back corrected data |
| wb_poison | output | NB | Per-beat poison mask for the write phase |

## Verification
The forced-insertion deadline is the hardest case to reach, because it only appears once the controller has stayed busy for the whole interval. The bench holds `ctl_idle` low after a scrub and counts cycles from the read grant to the next request, in both pacing modes. It also switches the pacing mode just before a grant, to show that the new interval takes effect at the reload. Poison groups are exercised with flagged beats that are not on a group boundary, and with two flagged beats in different groups. The address limit is set low, so the walk wraps within the run.

// File: rtl/scrub_pkg.sv
`timescale 1ns/1ps
package scrub_pkg;
  typedef enum logic [1:0] {
    S_WAIT    = 2'd0,
    S_RD_REQ  = 2'd1,
    S_RD_DATA = 2'd2,
    S_WR_REQ  = 2'd3
  } scrub_state_t;
endpackage

// File: rtl/scrub_pacer.sv
`timescale 1ns/1ps
module scrub_pacer #(
  parameter int IW          = 32,
  parameter int FIXED_TICKS = 16000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_fixed,
  input  logic [IW-1:0] cfg_interval,
  input  logic          reload,
  output logic          expired
);
  localparam logic [IW-1:0] FIXED_VAL = IW'(FIXED_TICKS);

  logic [IW-1:0] cnt;
  logic [IW-1:0] load_val;

  assign load_val = cfg_fixed ? FIXED_VAL : cfg_interval;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R4: a fixed-mode reload starts the window at the fixed tick count
  p_fixed_load_r4: assert property (@(posedge clk) disable iff (rst)
    reload && cfg_fixed |=> cnt == FIXED_VAL);

  // R3: without a reload the window only shrinks
  p_window_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
    !reload && !expired |=> cnt < $past(cnt));
endmodule

// File: rtl/scrub_poison.sv
`timescale 1ns/1ps
module scrub_poison #(
  parameter int NB = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  beat_valid,
  input  logic                  beat_ue,
  input  logic [$clog2(NB)-1:0] beat_idx,
  input  logic                  grp4,
  output logic [NB-1:0]         mask
);
  localparam int BW = $clog2(NB);

  logic [NB-1:0] grp_mask;

  for (genvar g = 0; g < NB; g++) begin : g_grp
    localparam logic [BW-1:0] GI = BW'(g);
    assign grp_mask[g] = grp4 ? (beat_idx[BW-1:2] == GI[BW-1:2])
                              : (beat_idx[BW-1:1] == GI[BW-1:1]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask <= '0;
    end else if (beat_valid && beat_ue) begin
      mask <= mask | grp_mask;
    end
  end

  // R8: the flagged beat itself is always poisoned
  p_flag_beat_r8: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ue && !clr |=> mask[$past(beat_idx)]);

  // R9: one flagged beat adds at most one group worth of bits
  p_group_bound_r9: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ue && !clr |=>
      $countones(mask & ~$past(mask)) <= (grp4 ? 4 : 2));
endmodule

// File: rtl/scrub_engine.sv
`timescale 1ns/1ps
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int AW          = 24,
  parameter int IW          = 32,
  parameter int NB          = 16,
  parameter int FIXED_TICKS = 16000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_bl16,
  input  logic          cfg_grp4,
  input  logic          cfg_fixed,
  input  logic [IW-1:0] cfg_interval,
  input  logic [AW-1:0] cfg_last_addr,
  input  logic          ctl_idle,
  input  logic          scrub_gnt,
  input  logic          rd_valid,
  input  logic          rd_ce,
  input  logic          rd_ue,
  output logic          scrub_req,
  output logic          scrub_wr,
  output logic          scrub_force,
  output logic [AW-1:0] scrub_addr,
  output logic          wb_fix,
  output logic [NB-1:0] wb_poison
);
  localparam int BW = $clog2(NB);
  localparam logic [BW-1:0] LAST_LONG  = BW'(NB - 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(NB / 2 - 1);

  scrub_state_t  state;
  logic [AW-1:0] addr;
  logic [BW-1:0] beat;
  logic          fix_r;
  logic          force_r;
  logic          expired;
  logic          rd_grant;
  logic          wr_grant;
  logic          take_beat;
  logic [BW-1:0] last_beat;

  assign rd_grant  = (state == S_RD_REQ) && scrub_gnt;
  assign wr_grant  = (state == S_WR_REQ) && scrub_gnt;
  assign take_beat = (state == S_RD_DATA) && rd_valid;
  assign last_beat = cfg_bl16 ? LAST_LONG : LAST_SHORT;

  scrub_pacer #(.IW(IW), .FIXED_TICKS(FIXED_TICKS)) u_pacer (
    .clk          (clk),
    .rst          (rst),
    .cfg_fixed    (cfg_fixed),
    .cfg_interval (cfg_interval),
    .reload       (rd_grant),
    .expired      (expired)
  );

  scrub_poison #(.NB(NB)) u_poison (
    .clk        (clk),
    .rst        (rst),
    .clr        (rd_grant),
    .beat_valid (take_beat),
    .beat_ue    (rd_ue),
    .beat_idx   (beat),
    .grp4       (cfg_grp4),
    .mask       (wb_poison)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_WAIT;
      addr    <= '0;
      beat    <= '0;
      fix_r   <= 1'b0;
      force_r <= 1'b0;
    end else begin
      unique case (state)
        S_WAIT: begin
          if (ctl_idle || expired) begin
            state   <= S_RD_REQ;
            force_r <= !ctl_idle;
          end
        end
        S_RD_REQ: begin
          if (scrub_gnt) begin
            state   <= S_RD_DATA;
            beat    <= '0;
            fix_r   <= 1'b0;
            force_r <= 1'b0;
          end
        end
        S_RD_DATA: begin
          if (rd_valid) begin
            fix_r <= fix_r | rd_ce;
            beat  <= beat + 1'b1;
            if (beat == last_beat) state <= S_WR_REQ;
          end
        end
        S_WR_REQ: begin
          if (scrub_gnt) begin
            state <= S_WAIT;
            addr  <= (addr == cfg_last_addr) ? '0 : addr + 1'b1;
          end
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  assign scrub_req   = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign scrub_wr    = (state == S_WR_REQ);
  assign scrub_force = force_r;
  assign scrub_addr  = addr;
  assign wb_fix      = (state == S_WR_REQ) && fix_r;

  // R5: an ungranted command is held unchanged
  p_hold_req_r5: assert property (@(posedge clk) disable iff (rst)
    scrub_req && !scrub_gnt |=>
      scrub_req && $stable(scrub_addr) && $stable(scrub_wr));

  // R6: last read beat is followed by a write request
  p_write_follows_r6: assert property (@(posedge clk) disable iff (rst)
    take_beat && beat == last_beat |=> scrub_req && scrub_wr);

  // R11: step and wrap of the walk address
  p_addr_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    wr_grant && scrub_addr == cfg_last_addr |=> scrub_addr == '0);
  p_addr_step_r11: assert property (@(posedge clk) disable iff (rst)
    wr_grant && scrub_addr != cfg_last_addr |=>
      scrub_addr == $past(scrub_addr) + 1'b1);

  // R3: a forced read only follows a busy controller
  p_force_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) && expired && !ctl_idle |=> scrub_force && scrub_req);
endmodule

// File: tb/sim_scrub_engine.sv
`timescale 1ns/1ps
module sim_scrub_engine;
  localparam int AW = 4;
  localparam int IW = 16;
  localparam int NB = 16;
  localparam int FT = 20;
  localparam logic [AW-1:0] LAST = 4'd5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_bl16 = 1'b0, cfg_grp4 = 1'b0, cfg_fixed = 1'b0;
  logic [IW-1:0] cfg_interval = 16'd30;
  logic [AW-1:0] cfg_last_addr = LAST;
  logic          ctl_idle = 1'b0, scrub_gnt = 1'b0;
  logic          rd_valid = 1'b0, rd_ce = 1'b0, rd_ue = 1'b0;
  logic          scrub_req, scrub_wr, scrub_force, wb_fix;
  logic [AW-1:0] scrub_addr;
  logic [NB-1:0] wb_poison;

  int checks = 0, errors = 0, cyc = 0, cyc_rd = 0;
  logic [AW-1:0] exp_addr = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scrub_engine #(.AW(AW), .IW(IW), .NB(NB), .FIXED_TICKS(FT)) u0 (
    .clk(clk), .rst(rst), .cfg_bl16(cfg_bl16), .cfg_grp4(cfg_grp4),
    .cfg_fixed(cfg_fixed), .cfg_interval(cfg_interval),
    .cfg_last_addr(cfg_last_addr), .ctl_idle(ctl_idle),
    .scrub_gnt(scrub_gnt), .rd_valid(rd_valid), .rd_ce(rd_ce),
    .rd_ue(rd_ue), .scrub_req(scrub_req), .scrub_wr(scrub_wr),
    .scrub_force(scrub_force), .scrub_addr(scrub_addr),
    .wb_fix(wb_fix), .wb_poison(wb_poison));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(scrub_req == 1'b0, "R1 req in reset", 32'(scrub_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(scrub_req == 1'b0, "R1 req after reset", 32'(scrub_req), 0);
    chk(scrub_addr == '0, "R1 addr", 32'(scrub_addr), 0);
    chk(wb_fix == 1'b0 && wb_poison == '0, "R1 fix/poison",
        32'({wb_fix, wb_poison}), 0);
  endtask

  task automatic start_idle();
    ctl_idle = 1'b1;
    @(negedge clk);
    ctl_idle = 1'b0;
    chk(scrub_req && !scrub_wr && !scrub_force, "R2 idle read request",
        32'({scrub_req, scrub_wr, scrub_force}), 32'b100);
  endtask

  task automatic wait_forced(input int exp_gap, input string req);
    int guard = 0;
    while (!scrub_req && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk(cyc - cyc_rd == exp_gap, req, 32'(cyc - cyc_rd), 32'(exp_gap));
    chk(scrub_force && !scrub_wr, {req, " forced flag"},
        32'({scrub_force, scrub_wr}), 32'b10);
  endtask

  task automatic run_scrub(input logic [15:0] ue, input logic [15:0] ce,
                           input int nb, input logic [15:0] exp_mask,
                           input logic exp_fix, input string req);
    chk(scrub_req && !scrub_wr, "R6 read phase", 32'({scrub_req, scrub_wr}), 32'b10);
    chk(scrub_addr == exp_addr, "R11 read addr", 32'(scrub_addr), 32'(exp_addr));
    scrub_gnt = 1'b1;
    @(negedge clk);
    scrub_gnt = 1'b0;
    cyc_rd = cyc;
    for (int i = 0; i < nb; i++) begin
      rd_valid = 1'b1; rd_ce = ce[i]; rd_ue = ue[i];
      @(negedge clk);
    end
    rd_valid = 1'b0; rd_ce = 1'b0; rd_ue = 1'b0;
    chk(scrub_req && scrub_wr, "R6 write after last beat",
        32'({scrub_req, scrub_wr}), 32'b11);
    chk(scrub_addr == exp_addr, "R6 write addr", 32'(scrub_addr), 32'(exp_addr));
    chk(wb_poison == exp_mask, req, 32'(wb_poison), 32'(exp_mask));
    chk(wb_fix == exp_fix, {req, " fix"}, 32'(wb_fix), 32'(exp_fix));
    scrub_gnt = 1'b1;
    @(negedge clk);
    scrub_gnt = 1'b0;
    exp_addr = (exp_addr == LAST) ? '0 : exp_addr + 1'b1;
    chk(!scrub_req && scrub_addr == exp_addr, "R11 addr step",
        32'({scrub_req, scrub_addr}), 32'(exp_addr));
  endtask

  task automatic t_hold();
    logic [AW-1:0] a0 = scrub_addr;
    repeat (4) @(negedge clk);
    chk(scrub_req && !scrub_wr && scrub_addr == a0, "R5 held request",
        32'({scrub_req, scrub_wr, scrub_addr}), 32'({2'b10, a0}));
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    start_idle();
    run_scrub(16'h0000, 16'h0000, 8, 16'h0000, 1'b0, "R6 clean burst");
    wait_forced(31, "R3 forced gap");
    t_hold();
    run_scrub(16'h0000, 16'h0008, 8, 16'h0000, 1'b1, "R7 correctable only");
    cfg_fixed = 1'b1;
    wait_forced(31, "R3 forced gap 2");
    run_scrub(16'h0002, 16'h0000, 8, 16'h0003, 1'b0, "R8 beat1 pair");
    wait_forced(FT + 1, "R4 fixed interval");
    cfg_fixed = 1'b0;
    run_scrub(16'h0042, 16'h0008, 8, 16'h00C3, 1'b1, "R10 mixed burst");
    cfg_grp4 = 1'b1;
    start_idle();
    run_scrub(16'h0020, 16'h0000, 8, 16'h00F0, 1'b0, "R9 beat5 quad bl8");
    cfg_bl16 = 1'b1;
    start_idle();
    run_scrub(16'h0040, 16'h0000, 16, 16'h00F0, 1'b0, "R9 beat6 quad");
    start_idle();
    run_scrub(16'h2040, 16'h0001, 16, 16'hF0F0, 1'b1, "R9 beats6+13");
    start_idle();
    chk(scrub_addr == exp_addr, "R12 walk continues after UE",
        32'(scrub_addr), 32'(exp_addr));
    run_scrub(16'h0000, 16'h0000, 16, 16'h0000, 1'b0, "R12 clean after UE");
    finish_run();
  end
endmodule